// File: doc/BRIEF.md
# Bus Parity Generator and Error Reporter

This block produces and checks even parity for a 32-bit multiplexed address/data bus and its 4-bit active-low command/byte-enable lines. On the driving side, the parity bit for the values the agent puts on the bus in one clock is presented in the following clock, because bus parity trails the lines it protects by one cycle.

On the receiving side, the block samples the bus together with phase qualifiers and recomputes parity. One clock later it compares the result with the parity line. A mismatch on an ordinary completed data beat starts a parity-error pulse. That pulse is active low and is released in two steps: first the line is driven high for one clock, then the output enable is dropped. A mismatch in an address phase, or on a data beat of a special cycle (command 0001), is reported on a system-error line instead. That line can only be pulled low.

Separate enables gate the two reports. Two sticky flags record every detected error until a clear strobe is applied.

Top module: `busparity_guard`

## Requirements
- R1: When `par_oe` is 1, the count of ones across `par_out` and the `drv_ad`/`drv_cbe_n` values sampled on the previous rising edge is even.
- R2: `par_oe` equals the value of `drv_en` sampled on the previous rising edge, and `par_out` then covers that edge's `drv_ad` and `drv_cbe_n`.
- R3: The following are checked:
  - a data beat (`data_beat`=1, `addr_phase`=0) sampled on edge k, against `bus_par` sampled on edge k+1;
  - an address phase (`addr_phase`=1), against `bus_par` sampled on edge k+1.
  - Cycles with neither qualifier never raise an error.
  - `addr_phase` takes priority over `data_beat`.
- R4: For a data-beat mismatch with `special_cyc`=0 and `perr_en`=1 at edge k+2, `perr_n_out`=0 and `perr_oe`=1 hold from edge k+2 to edge k+3.
- R5: Mismatching data beats on consecutive edges keep `perr_n_out` low without a gap. After the last low clock, one clock follows with `perr_oe`=1 and `perr_n_out`=1, and then `perr_oe` returns to 0.
- R6: An address-phase mismatch, or a data-beat mismatch with `special_cyc`=1, raises `serr_pull`=1 for exactly the clock after edge k+2 (when `serr_en`=1) and never touches the parity-error outputs. `serr_pull`=1 means "drive the line low"; the block has no output that drives it high.
- R7: With `perr_en`=0 at edge k+2, a data error leaves `perr_oe`=0. With `serr_en`=0 at edge k+2, a system error leaves `serr_pull`=0.
- R8: `perr_seen` (or `serr_seen`) becomes 1 after edge k+2 for every data (or system) error, whatever the enables. It clears on an edge where `clr_perr` (or `clr_serr`) is 1, unless a new error of that kind arrives on the same edge, in which case setting wins.
- R9: While `rst_n`=0, all outputs are 0 except `perr_n_out`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Agent drives AD and C/BE this cycle |
| drv_ad | input | 32 | Address/data value being driven |
| drv_cbe_n | input | 4 | Command/byte-enable value being driven (active low) |
| par_out | output | 1 | Generated parity, one clock late |
| par_oe | output | 1 | Output enable for `par_out` |
| bus_ad | input | 32 | Sampled address/data lines |
| bus_cbe_n | input | 4 | Sampled command/byte-enable lines |
| bus_par | input | 1 | Sampled parity line |
| addr_phase | input | 1 | This cycle is an address phase |
| data_beat | input | 1 | A data beat completes this cycle (both ready strobes low) |
| special_cyc | input | 1 | Current transaction is a special cycle |
| perr_en | input | 1 | Parity-error reporting enable |
| serr_en | input | 1 | System-error reporting enable |
| clr_perr | input | 1 | Clear strobe for `perr_seen` |
| clr_serr | input | 1 | Clear strobe for `serr_seen` |
| perr_n_out | output | 1 | Parity-error level to drive (active low) |
| perr_oe | output | 1 | Output enable for the parity-error line |
| serr_pull | output | 1 | Pull the system-error line low |
| perr_seen | output | 1 | Sticky data-parity error flag |
| serr_seen | output | 1 | Sticky system-error flag |

## Verification
The assertions take for granted that `addr_phase` and `data_beat` are never both set, and that `bus_par` always refers to the bus values of the previous clock. They do not assume that a data beat's parity was actually checked unless the qualifier was present two edges earlier.

The stimulus keeps the two phase qualifiers mutually exclusive and derives `bus_par` from the previously sampled lines, flipping it on purpose to inject errors. It also changes enables only through recorded per-edge values, so the expected outputs follow the same edge the design uses.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  typedef enum logic [1:0] {
    PE_IDLE = 2'd0,
    PE_LOW  = 2'd1,
    PE_HIGH = 2'd2
  } perr_state_e;

  typedef struct packed {
    logic chk_data;
    logic chk_sys;
    logic exp_par;
  } beat_tag_t;
endpackage

// File: rtl/bpg_parity.sv
module bpg_parity #(
  parameter int W = 36
) (
  input  logic [W-1:0] bits,
  output logic         odd
);
  logic [W:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_fold
    assign chain[g+1] = chain[g] ^ bits[g];
  end
  assign odd = chain[W];
endmodule

// File: rtl/bpg_drive.sv
module bpg_drive #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_en,
  input  logic [AD_W-1:0]  drv_ad,
  input  logic [CBE_W-1:0] drv_cbe_n,
  output logic             par_out,
  output logic             par_oe
);
  localparam int PW = AD_W + CBE_W;

  logic odd;
  logic par_d, par_q, oe_d, oe_q;

  bpg_parity #(.W(PW)) u_gen (.bits({drv_ad, drv_cbe_n}), .odd(odd));

  always_comb begin
    par_d = par_q;
    if (drv_en) par_d = odd;
    oe_d = drv_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_d;
      oe_q  <= oe_d;
    end
  end

  assign par_out = par_q;
  assign par_oe  = oe_q;

  a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ((^{par_out, $past(drv_ad), $past(drv_cbe_n)}) == 1'b0));
  a_r2_one_cycle_late: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> $past(drv_en));
endmodule

// File: rtl/bpg_check.sv
module bpg_check #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  bus_ad,
  input  logic [CBE_W-1:0] bus_cbe_n,
  input  logic             bus_par,
  input  logic             addr_phase,
  input  logic             data_beat,
  input  logic             special_cyc,
  output logic             data_err,
  output logic             sys_err
);
  import bpg_pkg::*;
  localparam int PW = AD_W + CBE_W;

  logic      odd;
  beat_tag_t s1_d, s1_q;
  logic      mismatch;
  logic      derr_d, derr_q, serr_d, serr_q;

  bpg_parity #(.W(PW)) u_chk (.bits({bus_ad, bus_cbe_n}), .odd(odd));

  always_comb begin
    s1_d.chk_sys  = addr_phase | (data_beat & special_cyc);
    s1_d.chk_data = data_beat & ~addr_phase & ~special_cyc;
    s1_d.exp_par  = odd;
    mismatch      = bus_par ^ s1_q.exp_par;
    derr_d        = s1_q.chk_data & mismatch;
    serr_d        = s1_q.chk_sys & mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      derr_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      derr_q <= derr_d;
      serr_q <= serr_d;
    end
  end

  assign data_err = derr_q;
  assign sys_err  = serr_q;

  a_r3_only_real_beats: assert property (@(posedge clk) disable iff (!rst_n)
    data_err |-> ($past(data_beat, 2) && !$past(addr_phase, 2)));
  a_r3_sys_has_qualifier: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |-> ($past(addr_phase, 2) || $past(data_beat & special_cyc, 2)));
  a_r6_kinds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_err && sys_err));
endmodule

// File: rtl/bpg_report.sv
module bpg_report (
  input  logic clk,
  input  logic rst_n,
  input  logic data_err,
  input  logic sys_err,
  input  logic perr_en,
  input  logic serr_en,
  input  logic clr_perr,
  input  logic clr_serr,
  output logic perr_n_out,
  output logic perr_oe,
  output logic serr_pull,
  output logic perr_seen,
  output logic serr_seen
);
  import bpg_pkg::*;

  perr_state_e st_d, st_q;
  logic        pull_d, pull_q;
  logic        pseen_d, pseen_q, sseen_d, sseen_q;
  logic        perr_req;

  always_comb begin
    perr_req = data_err & perr_en;
    if (perr_req)           st_d = PE_LOW;
    else if (st_q == PE_LOW) st_d = PE_HIGH;
    else                    st_d = PE_IDLE;

    pull_d = sys_err & serr_en;

    pseen_d = pseen_q;
    if (data_err)      pseen_d = 1'b1;
    else if (clr_perr) pseen_d = 1'b0;

    sseen_d = sseen_q;
    if (sys_err)       sseen_d = 1'b1;
    else if (clr_serr) sseen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PE_IDLE;
      pull_q  <= 1'b0;
      pseen_q <= 1'b0;
      sseen_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pull_q  <= pull_d;
      pseen_q <= pseen_d;
      sseen_q <= sseen_d;
    end
  end

  assign perr_n_out = (st_q != PE_LOW);
  assign perr_oe    = (st_q != PE_IDLE);
  assign serr_pull  = pull_q;
  assign perr_seen  = pseen_q;
  assign serr_seen  = sseen_q;

  a_r4_low_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err && perr_en) |=> (perr_oe && !perr_n_out));
  a_r5_drive_high_once: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out && !(data_err && perr_en)) |=> (perr_oe && perr_n_out));
  a_r5_then_release: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && perr_n_out && !(data_err && perr_en)) |=> !perr_oe);
  a_r6_serr_from_sys: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pull |-> $past(sys_err && serr_en));
  a_r7_gated_perr: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err && !perr_en) |=> perr_n_out);
  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err || sys_err) |=> (data_err ? 1'b1 : perr_seen) || serr_seen);
  a_r8_perr_seen_set: assert property (@(posedge clk) disable iff (!rst_n)
    data_err |=> perr_seen);
endmodule

// File: rtl/busparity_guard.sv
module busparity_guard #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_en,
  input  logic [AD_W-1:0]  drv_ad,
  input  logic [CBE_W-1:0] drv_cbe_n,
  output logic             par_out,
  output logic             par_oe,
  input  logic [AD_W-1:0]  bus_ad,
  input  logic [CBE_W-1:0] bus_cbe_n,
  input  logic             bus_par,
  input  logic             addr_phase,
  input  logic             data_beat,
  input  logic             special_cyc,
  input  logic             perr_en,
  input  logic             serr_en,
  input  logic             clr_perr,
  input  logic             clr_serr,
  output logic             perr_n_out,
  output logic             perr_oe,
  output logic             serr_pull,
  output logic             perr_seen,
  output logic             serr_seen
);
  logic data_err, sys_err;

  bpg_drive #(.AD_W(AD_W), .CBE_W(CBE_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_ad(drv_ad),
    .drv_cbe_n(drv_cbe_n), .par_out(par_out), .par_oe(par_oe)
  );

  bpg_check #(.AD_W(AD_W), .CBE_W(CBE_W)) u_check (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_cbe_n(bus_cbe_n),
    .bus_par(bus_par), .addr_phase(addr_phase), .data_beat(data_beat),
    .special_cyc(special_cyc), .data_err(data_err), .sys_err(sys_err)
  );

  bpg_report u_report (
    .clk(clk), .rst_n(rst_n), .data_err(data_err), .sys_err(sys_err),
    .perr_en(perr_en), .serr_en(serr_en), .clr_perr(clr_perr),
    .clr_serr(clr_serr), .perr_n_out(perr_n_out), .perr_oe(perr_oe),
    .serr_pull(serr_pull), .perr_seen(perr_seen), .serr_seen(serr_seen)
  );

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!par_oe && !perr_oe && !serr_pull && perr_n_out));
endmodule

// File: tb/sim_busparity_guard.sv
module sim_busparity_guard;
  localparam int N = 1600;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic drv_en; logic [31:0] drv_ad; logic [3:0] drv_cbe_n;
  logic par_out, par_oe;
  logic [31:0] bus_ad; logic [3:0] bus_cbe_n; logic bus_par;
  logic addr_phase, data_beat, special_cyc;
  logic perr_en, serr_en, clr_perr, clr_serr;
  logic perr_n_out, perr_oe, serr_pull, perr_seen, serr_seen;

  busparity_guard u0 (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] r_ad  [0:N]; logic [3:0] r_cbe [0:N];
  logic        r_addr[0:N], r_data[0:N], r_spec[0:N];
  logic        r_bd  [0:N], r_bs  [0:N], r_pen [0:N], r_sen[0:N];
  logic [31:0] r_dad [0:N]; logic [3:0] r_dcbe[0:N]; logic r_den[0:N];
  logic        e_pseen = 1'b0, e_sseen = 1'b0;

  // stimulus knobs
  int  k_kind = -1;   // -1 random, 0 idle, 1 addr, 2 data
  int  k_spec = -1;   // -1 random
  int  k_flip = 1;    // 0 never, 1 random, 2 always
  logic k_pen = 1'b1, k_sen = 1'b1;

  function automatic logic par36(input logic [31:0] a, input logic [3:0] c);
    return ^{a, c};
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    int  kind;
    logic flip, lo, oe_e, sp_e;
    cyc++;
    kind = (k_kind >= 0) ? k_kind : int'($urandom % 4);
    if (kind == 3) kind = 2;
    r_ad[cyc]   = $urandom;
    r_cbe[cyc]  = 4'($urandom);
    r_addr[cyc] = (kind == 1);
    r_data[cyc] = (kind == 2);
    r_spec[cyc] = (k_spec >= 0) ? k_spec[0] : (($urandom % 4) == 0);
    r_bd[cyc] = 1'b0; r_bs[cyc] = 1'b0;
    flip = (k_flip == 2) ? 1'b1 : (k_flip == 0) ? 1'b0 : (($urandom % 4) == 0);
    r_bd[cyc-1] = flip && r_data[cyc-1] && !r_spec[cyc-1];
    r_bs[cyc-1] = flip && (r_addr[cyc-1] || (r_data[cyc-1] && r_spec[cyc-1]));
    r_pen[cyc] = k_pen; r_sen[cyc] = k_sen;
    r_dad[cyc] = $urandom; r_dcbe[cyc] = 4'($urandom); r_den[cyc] = ($urandom % 3) != 0;
    bus_ad = r_ad[cyc]; bus_cbe_n = r_cbe[cyc];
    addr_phase = r_addr[cyc]; data_beat = r_data[cyc]; special_cyc = r_spec[cyc];
    bus_par = par36(r_ad[cyc-1], r_cbe[cyc-1]) ^ flip;
    perr_en = k_pen; serr_en = k_sen;
    clr_perr = (($urandom % 12) == 0); clr_serr = (($urandom % 12) == 0);
    drv_en = r_den[cyc]; drv_ad = r_dad[cyc]; drv_cbe_n = r_dcbe[cyc];
    @(posedge clk); #2;
    // expected values for this edge
    lo   = r_pen[cyc] && r_bd[cyc-2];
    oe_e = lo || (r_pen[cyc-1] && r_bd[cyc-3]);
    sp_e = r_sen[cyc] && r_bs[cyc-2];
    if (r_bd[cyc-2]) e_pseen = 1'b1; else if (clr_perr) e_pseen = 1'b0;
    if (r_bs[cyc-2]) e_sseen = 1'b1; else if (clr_serr) e_sseen = 1'b0;
    chk(r_bd[cyc-2] ? (r_pen[cyc] ? "R4 perr low" : "R7 perr gated") : "R3 perr quiet",
        perr_n_out, !lo);
    chk("R5 perr_oe sequencing", perr_oe, oe_e);
    chk(r_sen[cyc] ? "R6 serr pull" : "R7 serr gated", serr_pull, sp_e);
    chk("R8 perr_seen", perr_seen, e_pseen);
    chk("R8 serr_seen", serr_seen, e_sseen);
    chk("R2 par_oe", par_oe, r_den[cyc]);
    if (r_den[cyc])
      chk("R1 par_out even", par_out, par36(r_dad[cyc], r_dcbe[cyc]));
  endtask

  task automatic run(input int n);
    for (int j = 0; j < n; j++) step();
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int j = 0; j <= 2; j++) begin
      r_ad[j] = '0; r_cbe[j] = '0; r_addr[j] = 0; r_data[j] = 0; r_spec[j] = 0;
      r_bd[j] = 0; r_bs[j] = 0; r_pen[j] = 1; r_sen[j] = 1;
      r_dad[j] = '0; r_dcbe[j] = '0; r_den[j] = 0;
    end
    cyc = 2;
    rst_n = 1'b0;
    drv_en = 0; drv_ad = '0; drv_cbe_n = '0; bus_ad = '0; bus_cbe_n = '0; bus_par = 0;
    addr_phase = 0; data_beat = 0; special_cyc = 0;
    perr_en = 1; serr_en = 1; clr_perr = 0; clr_serr = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset perr_n", perr_n_out, 1'b1);
    chk("R9 reset perr_oe", perr_oe, 1'b0);
    chk("R9 reset serr", serr_pull, 1'b0);
    chk("R9 reset par_oe", par_oe, 1'b0);
    chk("R9 reset seen", perr_seen | serr_seen, 1'b0);
    rst_n = 1'b1;
    // directed: single bad data beat, then drain
    k_kind = 2; k_spec = 0; k_flip = 0; step();
    k_kind = 0; k_flip = 2; step();
    k_flip = 0; run(5);
    // directed: three back-to-back bad data beats (R5 continuous low)
    k_kind = 2; k_spec = 0; k_flip = 0; step();
    k_flip = 2; run(2);
    k_kind = 0; step();
    k_flip = 0; run(5);
    // directed: bad address phase and bad special-cycle beat (R6)
    k_kind = 1; step(); k_kind = 0; k_flip = 2; step(); k_flip = 0; run(4);
    k_kind = 2; k_spec = 1; step(); k_kind = 0; k_flip = 2; step(); k_flip = 0; run(4);
    // directed: idle cycles with wrong parity never flag (R3)
    k_kind = 0; k_flip = 2; run(6); k_flip = 0; run(3);
    // random with both enables
    k_kind = -1; k_spec = -1; k_flip = 1; run(500);
    // random with parity-error reporting off (R7)
    k_pen = 1'b0; run(250);
    k_pen = 1'b1; k_sen = 1'b0; run(250);
    k_sen = 1'b1; run(300);
    k_kind = 0; k_flip = 0; run(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog cycle %0d actual=hung expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule